// File: doc/BRIEF.md
# Prioritized Interrupt and Trap-Entry Unit

This unit holds a core's eight interrupt-pending flags and its supervisor trap registers: status, cause, exception PC and exception vector. In every cycle it decides whether a trap is taken. A synchronous exception reported by the pipeline always causes a trap. An interrupt causes a trap only when a pending flag is enabled by the status mask and traps are globally enabled. When a trap is taken, the unit performs the whole trap entry in one clock edge. It then pulses `trap_taken` and presents the vector on `redirect_pc` so that fetch can be redirected.

Every interrupt line has its own cause code, 16 plus the line index, and the lowest-numbered enabled line wins. Line 5 carries inter-processor interrupts and line 7 carries the timer. Reset does not jump to the vector directly. It leaves traps enabled, sets every mask bit and marks line 5 pending, as if the core had sent itself an inter-processor interrupt. The first cycle after reset therefore vectors to 0x2000 through the normal interrupt path. A return-from-trap strobe restores the status register. Software can write the status register and the vector register.

Top module: `irq_trap_unit`

## Requirements
- R1: During reset the outputs are: status 0x0000FF0B, vector 0x2000, cause 0, exception PC 0, redirect PC 0, pending 0x20 and `trap_taken` low. The status bits are: bit 0 traps enabled, bit 1 supervisor, bit 2 previous supervisor, bit 3 64-bit supervisor, and bits 15:8 the mask for lines 0..7.
- R2: On the first clock edge after reset is released, with no other input active, the boot interrupt on line 5 is taken. Cause becomes 21 and `redirect_pc` becomes 0x2000.
- R3: An interrupt is taken only when (pending AND status bits 15:8) is nonzero and status bit 0 is 1.
- R4: When several enabled lines are pending, the lowest-numbered line is taken, and the cause becomes 16 plus that line index.
- R5: A `exc_valid` cycle always causes a trap, whatever status bit 0 holds, and it wins over any interrupt in the same cycle. The cause becomes `exc_code` (0..15), zero-extended.
- R6: Trap entry has these effects:
  - status bit 0 is cleared, bit 1 is set, and bit 2 takes the old bit 1; all other status bits are unchanged;
  - the exception PC takes `cur_pc`;
  - the whole cause register is overwritten with the trap code.
- R7: `trap_taken` is high for exactly the cycle after each decision edge and low otherwise. `redirect_pc` then shows the vector value from before that edge and holds it until the next trap.
- R8: Each pending flag is set by its `pend_set` bit and cleared by its `pend_clr` bit, and set wins when both are high. A flag is otherwise held, including across trap entry.
- R9: `ret_valid` copies status bit 2 into bit 1 and sets bit 0. A trap in the same cycle takes precedence over `ret_valid`, and `ret_valid` takes precedence over a status write.
- R10: A status write stores only bits 0..3 and 15:8, and all other bits read 0. A vector write replaces the vector, and a trap in the same cycle redirects to the old vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Synchronous exception request |
| exc_code | input | 4 | Exception cause code 0..15 |
| cur_pc | input | 64 | PC of the current instruction |
| pend_set | input | 8 | Per-line pending set strobes |
| pend_clr | input | 8 | Per-line pending clear strobes |
| ret_valid | input | 1 | Return-from-trap status restore |
| sr_we | input | 1 | Status register write enable |
| sr_wdata | input | 32 | Status write data |
| evec_we | input | 1 | Vector register write enable |
| evec_wdata | input | 64 | Vector write data |
| trap_taken | output | 1 | One-cycle pulse after trap entry |
| redirect_pc | output | 64 | Fetch target of the last trap |
| status_q | output | 32 | Status register |
| cause_q | output | 8 | Cause register |
| epc_q | output | 64 | Exception PC register |
| evec_q | output | 64 | Exception vector register |
| pend_q | output | 8 | Interrupt-pending flags |

## Verification
Directed cases cover the boot interrupt and the case where an interrupt is pending while traps are disabled. They also cover two enabled lines pending together (lowest index wins) and a pending line whose mask bit is clear (it is not taken). An exception is raised while traps are off and again in the same cycle as a return, to separate exception precedence from the interrupt gate. Constrained-random cycles then mix exceptions, strobe bursts with set and clear overlapping, returns and register writes. This exposes ordering mistakes between the trap, the return, the status write and the pending update that the directed cases never line up.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int SR_W     = 32;
  localparam int SR_EN    = 0;
  localparam int SR_SUP   = 1;
  localparam int SR_PSUP  = 2;
  localparam int SR_S64   = 3;
  localparam int SR_IM_LO = 8;

  // Bits of the status register that hold state.
  function automatic logic [SR_W-1:0] sr_legal(input int nirq);
    logic [SR_W-1:0] m;
    m = '0;
    m[SR_EN] = 1'b1;
    m[SR_SUP] = 1'b1;
    m[SR_PSUP] = 1'b1;
    m[SR_S64] = 1'b1;
    for (int i = 0; i < nirq; i++) m[SR_IM_LO+i] = 1'b1;
    return m;
  endfunction

  // Boot status: every legal bit except previous-supervisor.
  function automatic logic [SR_W-1:0] sr_boot(input int nirq);
    logic [SR_W-1:0] m;
    m = sr_legal(nirq);
    m[SR_PSUP] = 1'b0;
    return m;
  endfunction

  function automatic logic [SR_W-1:0] sr_enter(input logic [SR_W-1:0] sr);
    logic [SR_W-1:0] r;
    r = sr;
    r[SR_PSUP] = sr[SR_SUP];
    r[SR_SUP] = 1'b1;
    r[SR_EN] = 1'b0;
    return r;
  endfunction

  function automatic logic [SR_W-1:0] sr_leave(input logic [SR_W-1:0] sr);
    logic [SR_W-1:0] r;
    r = sr;
    r[SR_SUP] = sr[SR_PSUP];
    r[SR_EN] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/trap_pend_bank.sv
module trap_pend_bank #(
  parameter int NIRQ = 8,
  parameter logic [NIRQ-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] set_i,
  input  logic [NIRQ-1:0] clr_i,
  output logic [NIRQ-1:0] pend_o
);
  for (genvar gi = 0; gi < NIRQ; gi++) begin : g_line
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)          bit_q <= RST_VAL[gi];
      else if (set_i[gi])  bit_q <= 1'b1;
      else if (clr_i[gi])  bit_q <= 1'b0;
    end
    assign pend_o[gi] = bit_q;
  end

  // R8: flags hold without strobes, whatever the trap logic does
  p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(pend_o));
  // R8: a set strobe always lands, even against a clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/trap_irq_arbiter.sv
module trap_irq_arbiter #(
  parameter int NIRQ = 8,
  localparam int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIRQ-1:0]  pend_i,
  input  logic [NIRQ-1:0]  mask_i,
  input  logic             en_i,
  output logic             req_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [NIRQ-1:0] masked;
  logic [NIRQ-1:0] below;

  always_comb begin
    masked = pend_i & mask_i;
    idx_o  = '0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (masked[i]) idx_o = IDX_W'(i);
    req_o = en_i && (masked != '0);
    below = (NIRQ'(1) << idx_o) - NIRQ'(1);
  end

  // R4: the chosen line is enabled and no lower line is
  p_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (masked[idx_o] && ((masked & below) == '0)));
endmodule

// File: rtl/trap_csr.sv
module trap_csr
  import trap_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int CAUSE_W = 8,
  parameter int NIRQ = 8,
  parameter logic [XLEN-1:0] EVEC_RST = 'h2000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire_i,
  input  logic [CAUSE_W-1:0] code_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               ret_i,
  input  logic               sr_we_i,
  input  logic [SR_W-1:0]    sr_wd_i,
  input  logic               ev_we_i,
  input  logic [XLEN-1:0]    ev_wd_i,
  output logic               taken_o,
  output logic [XLEN-1:0]    redir_o,
  output logic [SR_W-1:0]    sr_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [XLEN-1:0]    evec_o
);
  localparam logic [SR_W-1:0] LEGAL  = sr_legal(NIRQ);
  localparam logic [SR_W-1:0] SR_RST = sr_boot(NIRQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_o    <= SR_RST;
      cause_o <= '0;
      epc_o   <= '0;
      evec_o  <= EVEC_RST;
      taken_o <= 1'b0;
      redir_o <= '0;
    end else begin
      taken_o <= fire_i;
      if (fire_i) begin
        sr_o    <= sr_enter(sr_o);
        cause_o <= code_i;
        epc_o   <= pc_i;
        redir_o <= evec_o;
      end else if (ret_i) begin
        sr_o <= sr_leave(sr_o);
      end else if (sr_we_i) begin
        sr_o <= sr_wd_i & LEGAL;
      end
      if (ev_we_i) evec_o <= ev_wd_i;
    end
  end

  // R6: entry state
  p_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> (!sr_o[SR_EN] && sr_o[SR_SUP] && sr_o[SR_PSUP] == $past(sr_o[SR_SUP])
                && epc_o == $past(pc_i) && cause_o == $past(code_i)));
  // R7: pulse and target
  p_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> (taken_o && redir_o == $past(evec_o)));
  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_i |=> (!taken_o && $stable(redir_o)));
  // R9: return restore when no trap competes
  p_ret_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !fire_i) |=> (sr_o[SR_EN] && sr_o[SR_SUP] == $past(sr_o[SR_PSUP])));
  // R10: undefined status bits stay zero
  p_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_o & ~LEGAL) == '0);
endmodule

// File: rtl/irq_trap_unit.sv
module irq_trap_unit
  import trap_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NIRQ = 8,
  parameter int EXC_W = 4,
  parameter int CAUSE_W = 8,
  parameter int IPI_LINE = 5,
  parameter bit BOOT_IPI = 1'b1,
  parameter logic [XLEN-1:0] EVEC_RST = 'h2000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_valid,
  input  logic [EXC_W-1:0]   exc_code,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic [NIRQ-1:0]    pend_set,
  input  logic [NIRQ-1:0]    pend_clr,
  input  logic               ret_valid,
  input  logic               sr_we,
  input  logic [31:0]        sr_wdata,
  input  logic               evec_we,
  input  logic [XLEN-1:0]    evec_wdata,
  output logic               trap_taken,
  output logic [XLEN-1:0]    redirect_pc,
  output logic [31:0]        status_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [XLEN-1:0]    epc_q,
  output logic [XLEN-1:0]    evec_q,
  output logic [NIRQ-1:0]    pend_q
);
  localparam int IRQ_BASE = 1 << EXC_W;
  localparam int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1;
  localparam logic [NIRQ-1:0] PEND_RST = BOOT_IPI ? (NIRQ'(1) << IPI_LINE) : '0;

  logic             irq_req;
  logic [IDX_W-1:0] irq_idx;
  logic             trap_fire;
  logic [CAUSE_W-1:0] trap_code;

  trap_pend_bank #(.NIRQ(NIRQ), .RST_VAL(PEND_RST)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(pend_set), .clr_i(pend_clr), .pend_o(pend_q));

  trap_irq_arbiter #(.NIRQ(NIRQ)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_q),
    .mask_i(status_q[SR_IM_LO +: NIRQ]), .en_i(status_q[SR_EN]),
    .req_o(irq_req), .idx_o(irq_idx));

  // Exceptions first, then the arbiter's line.
  assign trap_fire = exc_valid || irq_req;
  assign trap_code = exc_valid ? CAUSE_W'(exc_code)
                               : CAUSE_W'(IRQ_BASE) + CAUSE_W'(irq_idx);

  trap_csr #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .NIRQ(NIRQ), .EVEC_RST(EVEC_RST)) u_csr (
    .clk(clk), .rst_n(rst_n), .fire_i(trap_fire), .code_i(trap_code), .pc_i(cur_pc),
    .ret_i(ret_valid), .sr_we_i(sr_we), .sr_wd_i(sr_wdata),
    .ev_we_i(evec_we), .ev_wd_i(evec_wdata),
    .taken_o(trap_taken), .redir_o(redirect_pc), .sr_o(status_q),
    .cause_o(cause_q), .epc_o(epc_q), .evec_o(evec_q));

  // R5: exception always taken, its own code
  p_exc_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (trap_taken && cause_q == CAUSE_W'($past(exc_code))));
  // R3: interrupt causes only appear when traps were enabled
  p_irq_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_taken && cause_q >= CAUSE_W'(IRQ_BASE)) |-> $past(status_q[SR_EN]));
  // R7: a pulse needs a request in the cycle before
  p_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> $past(exc_valid || irq_req));
endmodule

// File: tb/irq_trap_unit_bench.sv
module irq_trap_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [3:0]  exc_code = '0;
  logic [63:0] cur_pc = '0;
  logic [7:0]  pend_set = '0, pend_clr = '0;
  logic        ret_valid = 1'b0, sr_we = 1'b0, evec_we = 1'b0;
  logic [31:0] sr_wdata = '0;
  logic [63:0] evec_wdata = '0;
  logic        trap_taken;
  logic [63:0] redirect_pc, epc_q, evec_q;
  logic [31:0] status_q;
  logic [7:0]  cause_q, pend_q;

  irq_trap_unit u_irq_trap_unit (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
    .cur_pc(cur_pc), .pend_set(pend_set), .pend_clr(pend_clr),
    .ret_valid(ret_valid), .sr_we(sr_we), .sr_wdata(sr_wdata),
    .evec_we(evec_we), .evec_wdata(evec_wdata), .trap_taken(trap_taken),
    .redirect_pc(redirect_pc), .status_q(status_q), .cause_q(cause_q),
    .epc_q(epc_q), .evec_q(evec_q), .pend_q(pend_q));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_sr;
  logic [7:0]  m_pend, m_cause;
  logic [63:0] m_epc, m_evec, m_rd;
  logic        m_tk;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // lowest set bit, searched upward
  function automatic int first_line(input logic [7:0] v);
    int r = -1;
    for (int i = 0; i < 8; i++) if (r < 0 && v[i]) r = i;
    return r;
  endfunction

  task automatic cmp_all(input string req);
    chk(req, "trap_taken", 64'(trap_taken), 64'(m_tk));
    chk(req, "redirect", redirect_pc, m_rd);
    chk(req, "status", 64'(status_q), 64'(m_sr));
    chk(req, "cause", 64'(cause_q), 64'(m_cause));
    chk(req, "epc", epc_q, m_epc);
    chk(req, "evec", evec_q, m_evec);
    chk(req, "pending", 64'(pend_q), 64'(m_pend));
  endtask

  task automatic step(input logic ev, input logic [3:0] ec, input logic [63:0] pc,
                      input logic [7:0] st, input logic [7:0] cl, input logic rt,
                      input logic sw, input logic [31:0] sd, input logic ew,
                      input logic [63:0] ed, input string req);
    logic [7:0] mk;
    logic irq;
    exc_valid = ev; exc_code = ec; cur_pc = pc; pend_set = st; pend_clr = cl;
    ret_valid = rt; sr_we = sw; sr_wdata = sd; evec_we = ew; evec_wdata = ed;
    mk  = m_pend & m_sr[15:8];
    irq = m_sr[0] && (mk != 0);
    if (ev || irq) begin
      m_cause = ev ? {4'd0, ec} : 8'(16 + first_line(mk));
      m_epc = pc;
      m_rd = m_evec;
      m_tk = 1'b1;
      m_sr = {m_sr[31:3], m_sr[1], 1'b1, 1'b0};
    end else begin
      m_tk = 1'b0;
      if (rt) m_sr = {m_sr[31:3], m_sr[2], m_sr[2], 1'b1};
      else if (sw) m_sr = sd & 32'h0000_FF0F;
    end
    if (rt && !(ev || irq)) m_sr[2] = m_sr[2];
    if (ew) m_evec = ed;
    m_pend = (m_pend & ~cl) | st;
    @(posedge clk);
    #1;
    cmp_all(req);
  endtask

  task automatic idle(input string req);
    step(0, 0, 64'h1000, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    m_sr = 32'h0000_FF0B; m_pend = 8'h20; m_cause = 0; m_epc = 0;
    m_evec = 64'h2000; m_rd = 0; m_tk = 0;
    cmp_all("R1");
    rst_n = 1'b1;

    // R2 boot IPI through the vector
    step(0, 0, 64'h40, 0, 0, 0, 0, 0, 0, 0, "R2");
    chk("R2", "boot cause", 64'(cause_q), 64'd21);
    chk("R2", "boot target", redirect_pc, 64'h2000);
    chk("R6", "entry status", 64'(status_q), 64'h0000_FF0E);
    // R3 pending but traps disabled: no trap, R8 flag held across entry
    idle("R3");
    chk("R8", "ipi still pending", 64'(pend_q), 64'h20);
    // R8 clear 5 and set 3,6; also set and clear 1 together (set wins)
    step(0, 0, 64'h44, 8'h4A, 8'h22, 0, 0, 0, 0, 0, "R8");
    chk("R8", "set wins", 64'(pend_q), 64'h4A);
    // R9 return re-enables
    step(0, 0, 64'h48, 0, 0, 1, 0, 0, 0, 0, "R9");
    // R4 lowest line (1) wins among 1,3,6
    step(0, 0, 64'h50, 0, 8'h02, 0, 0, 0, 0, 0, "R4");
    chk("R4", "lowest cause", 64'(cause_q), 64'd17);
    step(0, 0, 64'h54, 0, 0, 1, 0, 0, 0, 0, "R9");
    step(0, 0, 64'h58, 0, 0, 0, 0, 0, 0, 0, "R4");
    chk("R4", "next line", 64'(cause_q), 64'd19);
    // R10 status write with junk bits; mask only line 6, traps on
    step(0, 0, 64'h5C, 0, 0, 0, 1, 32'hABCD_4003, 1, 64'h3000, "R10");
    chk("R10", "legal bits", 64'(status_q), 64'h4003);
    // R3 masked line 3 ignored, line 6 taken; R10 new vector used
    step(0, 0, 64'h60, 0, 0, 0, 0, 0, 0, 0, "R3");
    chk("R3", "masked skip", 64'(cause_q), 64'd22);
    chk("R10", "new vector", redirect_pc, 64'h3000);
    // R5 exception with traps off
    step(1, 4'd9, 64'h64, 0, 0, 0, 0, 0, 0, 0, "R5");
    chk("R5", "exc cause", 64'(cause_q), 64'd9);
    // R9 trap beats return in same cycle
    step(1, 4'd15, 64'h68, 0, 0, 1, 0, 0, 0, 0, "R9");
    chk("R9", "trap over ret", 64'(status_q[0]), 64'd0);
    // R5 exception beats pending enabled interrupt
    step(0, 0, 64'h6C, 0, 0, 1, 0, 0, 0, 0, "R9");
    step(1, 4'd2, 64'h70, 0, 0, 0, 0, 0, 1, 64'h4000, "R5");
    chk("R5", "exc over irq", 64'(cause_q), 64'd2);
    chk("R10", "old vector on same-cycle write", redirect_pc, 64'h3000);
    idle("R7");
    chk("R7", "pulse ends", 64'(trap_taken), 64'd0);

    for (int k = 0; k < 600; k++) begin
      logic [7:0] st, cl;
      st = ($urandom % 4 == 0) ? 8'($urandom & $urandom) : 8'h0;
      cl = ($urandom % 3 == 0) ? 8'($urandom) : 8'h0;
      step($urandom % 9 == 0, 4'($urandom), {$urandom, $urandom}, st, cl,
           $urandom % 5 == 0, $urandom % 8 == 0, $urandom | 32'h1,
           $urandom % 20 == 0, {$urandom, $urandom}, "R6/R8 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule